// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block sits beside a DRAM controller and counts selected events from a wide vector of single-cycle performance strobes. It holds four counters. Counter 0 is a time base: it counts every clock while counting is enabled. When it wraps from all ones to zero, all four counters stop and an interrupt is raised. Both stay in place until software releases them. Counters 1 to 3 each count the event that their own event-select register names. They wrap silently when they overflow.

Two event codes count read or write beats that pass a single shared ID filter. The filter holds a reference ID and a participation mask. The read-side and write-side ID events both compare against these same values. A small word-addressed register port carries the rest:

- configuration, and a global enable;
- zeroing of all counters;
- release of the freeze, which also clears the interrupt;
- readback, where a counter's full value is captured in one cycle, so a read never mixes bits from two different counts.

Top module: `mc_perf_counters`

## Requirements
- R1: After reset all four counters read zero and `irq_o` is low. A read strobe at address 8+i captures counter i in full, and the value is on `reg_rdata_o` the cycle after the strobe. Address 0 reads the enable in bit 0. Address 1 reads the filter. Addresses 4..7 read the event selects in bits [7:0]. Any other address reads zero.
- R2: While enabled and not frozen, counter 0 adds one on every clock, whatever its event select holds.
- R3: For counters 1..3, an event select in the range 0..NUM_EV-1 adds one on each enabled, unfrozen cycle in which `perf_ev_i[code]` is 1.
- R4: When counter 0 steps from all ones to zero, `irq_o` goes high on the next cycle. From then on no counter changes until the freeze is released.
- R5: A write to address 0 with bit 2 set lowers `irq_o` and resumes counting from the next cycle. Counter values are kept.
- R6: Counters 1..3 wrap from all ones to zero and keep counting, and they never raise `irq_o`.
- R7: Event select 0x41 counts cycles with `rd_beat_i` high and a passing `rd_id_i`. Event select 0x42 does the same for `wr_beat_i` and `wr_id_i`.
- R8: The filter at address 1 holds the reference ID in bits [ID_W-1:0] and the mask in bits [16+ID_W-1:16]. An ID passes when (ID AND mask) equals (reference AND mask), so a mask bit of 0 removes that bit from the compare. Both ID events share this one filter.
- R9: An event select that names no event (for example 0x50) never increments its counter.
- R10: Every write to address 0 loads bit 0 as the global enable. While the enable is 0, no counter changes.
- R11: A write to address 0 with bit 1 set makes every counter read zero on the next cycle. This takes priority over any increment on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perf_ev_i | input | NUM_EV | Performance event strobes, one bit per event code |
| rd_beat_i | input | 1 | Read beat accepted this cycle |
| rd_id_i | input | ID_W | Read transaction ID |
| wr_beat_i | input | 1 | Write beat accepted this cycle |
| wr_id_i | input | ID_W | Write transaction ID |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after `reg_re_i` |
| irq_o | output | 1 | Time-base expiry interrupt |

## Verification
Writes, counter increments, zeroing and freeze release all take effect at the clock edge that samples them. A read strobe shows its data one cycle later, and that data is the state from before that same edge. A wrap of counter 0 raises `irq_o` one cycle after the all-ones step. The bench's reference model follows the same ordering: at each rising edge it first captures the read value, then applies increments, zeroing, wrap and register writes. It compares `irq_o` on every falling edge, and compares `reg_rdata_o` on the falling edge after each read strobe. The counter width is reduced in the bench, so that counter 0 expires and counter 1 wraps within a short run.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int NUM_CNT       = 4;
  localparam int CODE_W        = 8;
  localparam int A_CTRL        = 0;
  localparam int A_FILT        = 1;
  localparam int A_CFG0        = 4;
  localparam int A_CNT0        = 8;
  localparam int CTL_EN        = 0;
  localparam int CTL_ZERO      = 1;
  localparam int CTL_RESUME    = 2;
  localparam int FILT_MASK_LSB = 16;
  localparam logic [CODE_W-1:0] EV_ID_RD = 8'h41;
  localparam logic [CODE_W-1:0] EV_ID_WR = 8'h42;
endpackage

// File: rtl/pm_id_filter.sv
module pm_id_filter #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] ref_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            pass_o
);
  // only bits with mask=1 take part in the compare (R8)
  assign pass_o = ((id_i ^ ref_i) & mask_i) == '0;
endmodule

// File: rtl/pm_event_mux.sv
module pm_event_mux
  import perfmon_pkg::*;
#(
  parameter int NUM_EV = 32
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [NUM_EV-1:0] perf_ev_i,
  input  logic              rd_hit_i,
  input  logic              wr_hit_i,
  output logic              hit_o
);
  localparam int SEL_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;

  always_comb begin
    hit_o = 1'b0;
    if (code_i == EV_ID_RD) begin
      hit_o = rd_hit_i;                          // R7
    end else if (code_i == EV_ID_WR) begin
      hit_o = wr_hit_i;                          // R7
    end else if (int'(code_i) < NUM_EV) begin
      hit_o = perf_ev_i[code_i[SEL_W-1:0]];      // R3
    end                                          // otherwise R9: no event
  end
endmodule

// File: rtl/pm_count_slice.sv
module pm_count_slice #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d = cnt_q;
    if (zero_i)     cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  assign cnt_ce = zero_i | inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~zero_i & (&cnt_q);

  // an increment adds exactly one, with wrap (R2, R3, R6)
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !zero_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> cnt_q == '0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !zero_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mc_perf_counters.sv
module mc_perf_counters
  import perfmon_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_EV = 32,
  parameter int ID_W   = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] perf_ev_i,
  input  logic              rd_beat_i,
  input  logic [ID_W-1:0]   rd_id_i,
  input  logic              wr_beat_i,
  input  logic [ID_W-1:0]   wr_id_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int FLAT_W = NUM_CNT * CNT_W;

  // control state
  logic              en_q, en_d;
  logic              halt_q, halt_d;
  logic [ID_W-1:0]   fid_q, fid_d;
  logic [ID_W-1:0]   fmask_q, fmask_d;
  logic [CODE_W-1:0] cfg_q [NUM_CNT];
  logic [31:0]       rdata_q, rdata_d;

  logic              wr_ctrl, wr_filt;
  logic              zero_all, resume, run;
  logic              rd_pass, wr_pass, rd_hit, wr_hit;
  logic [NUM_CNT-1:0] inc, wrap, ev_hit;
  logic [CNT_W-1:0]  cnt [NUM_CNT];
  logic [FLAT_W-1:0] cnt_flat;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign wr_filt  = reg_we_i && (reg_addr_i == ADDR_W'(A_FILT));
  assign zero_all = wr_ctrl & reg_wdata_i[CTL_ZERO];
  assign resume   = wr_ctrl & reg_wdata_i[CTL_RESUME];
  assign run      = en_q & ~halt_q;

  // shared ID filter, one compare per direction
  pm_id_filter #(.ID_W(ID_W)) u_rd_filt (
    .id_i(rd_id_i), .ref_i(fid_q), .mask_i(fmask_q), .pass_o(rd_pass));
  pm_id_filter #(.ID_W(ID_W)) u_wr_filt (
    .id_i(wr_id_i), .ref_i(fid_q), .mask_i(fmask_q), .pass_o(wr_pass));

  assign rd_hit = rd_beat_i & rd_pass;
  assign wr_hit = wr_beat_i & wr_pass;

  // next state of control registers
  always_comb begin
    en_d    = en_q;
    fid_d   = fid_q;
    fmask_d = fmask_q;
    halt_d  = halt_q;
    if (wr_ctrl) en_d = reg_wdata_i[CTL_EN];
    if (wr_filt) begin
      fid_d   = reg_wdata_i[ID_W-1:0];
      fmask_d = reg_wdata_i[FILT_MASK_LSB +: ID_W];
    end
    if (wrap[0])     halt_d = 1'b1;
    else if (resume) halt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      fid_q   <= '0;
      fmask_q <= '0;
    end else begin
      en_q    <= en_d;
      halt_q  <= halt_d;
      fid_q   <= fid_d;
      fmask_q <= fmask_d;
    end
  end

  assign irq_o = halt_q;

  // per-counter config, event selection and counting
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic cfg_we;
    assign cfg_we = reg_we_i && (reg_addr_i == ADDR_W'(A_CFG0 + i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[i] <= '0;
      else if (cfg_we) cfg_q[i] <= reg_wdata_i[CODE_W-1:0];
    end

    pm_event_mux #(.NUM_EV(NUM_EV)) u_mux (
      .code_i(cfg_q[i]), .perf_ev_i(perf_ev_i),
      .rd_hit_i(rd_hit), .wr_hit_i(wr_hit), .hit_o(ev_hit[i]));

    if (i == 0) begin : g_time
      assign inc[i] = run;                    // R2: time base
    end else begin : g_event
      assign inc[i] = run & ev_hit[i];
    end

    pm_count_slice #(.CNT_W(CNT_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .inc_i(inc[i]), .zero_i(zero_all),
      .cnt_o(cnt[i]), .wrap_o(wrap[i]));

    assign cnt_flat[i*CNT_W +: CNT_W] = cnt[i];
  end

  // readback: full value captured in one register stage
  always_comb begin
    rdata_d = '0;
    if (reg_addr_i == ADDR_W'(A_CTRL)) rdata_d[CTL_EN] = en_q;
    if (reg_addr_i == ADDR_W'(A_FILT)) begin
      rdata_d[ID_W-1:0]              = fid_q;
      rdata_d[FILT_MASK_LSB +: ID_W] = fmask_q;
    end
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr_i == ADDR_W'(A_CFG0 + i)) rdata_d[CODE_W-1:0] = cfg_q[i];
      if (reg_addr_i == ADDR_W'(A_CNT0 + i)) rdata_d[CNT_W-1:0]  = cnt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;

  // freeze holds every counter
  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !zero_all) |=> $stable(cnt_flat));
  // interrupt rises only after counter 0 was all ones
  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(&cnt[0]));
  // wraps of counters 1..3 never raise the interrupt
  assert_no_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !wrap[0]) |=> !irq_o);
  assert_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && resume) |=> !irq_o);
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !zero_all) |=> $stable(cnt_flat));
endmodule

// File: tb/test_mc_perf_counters.sv
module test_mc_perf_counters;
  localparam int CNT_W  = 10;
  localparam int NUM_EV = 32;
  localparam int ID_W   = 16;
  localparam int ADDR_W = 4;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic              clk, rst_n;
  logic [NUM_EV-1:0] perf_ev;
  logic              rd_beat, wr_beat;
  logic [ID_W-1:0]   rd_id, wr_id;
  logic              reg_we, reg_re;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic              irq;

  int n_chk = 0, n_bad = 0;
  int stim_mode = 0;   // 0 quiet, 1 random, 2 all ones, 3 event 0 only
  bit done = 0;

  mc_perf_counters #(.CNT_W(CNT_W), .NUM_EV(NUM_EV), .ID_W(ID_W), .ADDR_W(ADDR_W)) i_mc_perf_counters (
    .clk(clk), .rst_n(rst_n), .perf_ev_i(perf_ev), .rd_beat_i(rd_beat), .rd_id_i(rd_id),
    .wr_beat_i(wr_beat), .wr_id_i(wr_id), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq));

  initial clk = 0;
  always #10 clk = ~clk;   // 50 MHz

  // ---------------- reference model ----------------
  longint m_cnt [4];
  int     m_cfg [4];
  bit     m_en, m_halt, m_pend;
  int     m_fid, m_fmask;
  longint m_rexp;
  string  m_rtag;

  function automatic bit id_ok(int id);
    return ((id ^ m_fid) & m_fmask & 32'hFFFF) == 0;
  endfunction

  function automatic bit ev_on(int code);
    if (code == 'h41) return rd_beat && id_ok(int'(rd_id));
    if (code == 'h42) return wr_beat && id_ok(int'(wr_id));
    if (code < NUM_EV) return perf_ev[code];
    return 0;
  endfunction

  function automatic longint model_read(int a);
    if (a == 0) return longint'(m_en);
    if (a == 1) return longint'(m_fid) | (longint'(m_fmask) << 16);
    if (a >= 4 && a <= 7) return longint'(m_cfg[a-4]);
    if (a >= 8 && a <= 11) return m_cnt[a-8];
    return 0;
  endfunction

  function automatic string tag_of(int a);
    case (a)
      8:  return "R1 R2";
      9:  return "R3 R6";
      10: return "R7 R8";
      11: return "R7 R9";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_cfg[i] = 0; end
      m_en = 0; m_halt = 0; m_fid = 0; m_fmask = 0; m_pend = 0;
    end else begin
      bit wrap0, zero, res;
      longint nxt [4];
      m_pend = reg_re;
      if (reg_re) begin
        m_rexp = model_read(int'(reg_addr));
        m_rtag = tag_of(int'(reg_addr));
      end
      wrap0 = 0;
      for (int i = 0; i < 4; i++) begin
        nxt[i] = m_cnt[i];
        if (m_en && !m_halt && (i == 0 || ev_on(m_cfg[i]))) begin
          nxt[i] = (m_cnt[i] + 1) & CMAX;
          if (i == 0 && m_cnt[0] == CMAX) wrap0 = 1;
        end
      end
      zero = reg_we && reg_addr == 0 && reg_wdata[1];
      res  = reg_we && reg_addr == 0 && reg_wdata[2];
      if (zero) begin
        for (int i = 0; i < 4; i++) nxt[i] = 0;
        wrap0 = 0;
      end
      for (int i = 0; i < 4; i++) m_cnt[i] = nxt[i];
      if (wrap0) m_halt = 1;
      else if (res) m_halt = 0;
      if (reg_we) begin
        if (reg_addr == 0) m_en = reg_wdata[0];
        if (reg_addr == 1) begin m_fid = int'(reg_wdata[15:0]); m_fmask = int'(reg_wdata[31:16]); end
        if (reg_addr >= 4 && reg_addr <= 7) m_cfg[reg_addr-4] = int'(reg_wdata[7:0]);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (irq !== m_halt) begin
        n_bad++;
        $display("FAIL R4 R5 R6 irq: actual %0b expected %0b at %0t", irq, m_halt, $time);
      end
      if (m_pend) begin
        n_chk++;
        if (longint'(reg_rdata) != m_rexp) begin
          n_bad++;
          $display("FAIL %s read: actual %0h expected %0h at %0t", m_rtag, reg_rdata, m_rexp, $time);
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  always @(negedge clk) begin
    case (stim_mode)
      1: begin
        perf_ev <= $urandom;
        rd_beat <= 1'($urandom);
        wr_beat <= 1'($urandom);
        rd_id   <= ($urandom % 2) ? {8'($urandom), 8'h12} : 16'($urandom);
        wr_id   <= ($urandom % 2) ? {8'($urandom), 8'h12} : 16'($urandom);
      end
      2: begin perf_ev <= '1; rd_beat <= 1; wr_beat <= 1; rd_id <= 16'h0012; wr_id <= 16'h0012; end
      3: begin perf_ev <= 32'h1; rd_beat <= 0; wr_beat <= 0; end
      default: begin perf_ev <= '0; rd_beat <= 0; wr_beat <= 0; rd_id <= '0; wr_id <= '0; end
    endcase
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we <= 1; reg_addr <= ADDR_W'(a); reg_wdata <= d;
    @(negedge clk);
    reg_we <= 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_re <= 1; reg_addr <= ADDR_W'(a);
    @(negedge clk);
    reg_re <= 0;
    #1 v = reg_rdata;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sweep(input int rounds);
    logic [31:0] v;
    for (int k = 0; k < rounds; k++) begin
      rd(8 + (k % 4), v);
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 0; reg_we = 0; reg_re = 0; reg_addr = '0; reg_wdata = '0;
    perf_ev = '0; rd_beat = 0; wr_beat = 0; rd_id = '0; wr_id = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk("R1 irq after reset", irq, 0);
    for (int i = 0; i < 4; i++) begin rd(8 + i, v); chk("R1 counter after reset", v, 0); end

    // configuration; counter 0 select is ignored (R2)
    wr(4, 32'h42);
    wr(5, 32'h00);
    wr(6, 32'h41);
    wr(7, 32'h42);
    wr(1, {16'h00FF, 16'h0012});
    rd(1, v); chk("R8 filter readback", v, {16'h00FF, 16'h0012});

    // R10: disabled, events present, nothing counts
    stim_mode = 1;
    repeat (40) @(negedge clk);
    rd(9, v); chk("R10 disabled counter", v, 0);

    // R2 R3 R7 R8: enabled random traffic, model-compared reads
    wr(0, 32'h1);
    sweep(80);
    // R8: empty mask lets every beat pass
    wr(1, {16'h0000, 16'h0012});
    sweep(30);

    // R9: unknown code on counter 3
    wr(7, 32'h50);
    wr(0, 32'h3);
    stim_mode = 2;
    repeat (100) @(negedge clk);
    rd(11, v); chk("R9 unknown event code", v, 0);

    // R10 R11: zero while disabling
    wr(0, 32'h2);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 4; i++) begin rd(8 + i, v); chk("R10 R11 zeroed and held", v, 0); end

    // R4: run to expiry
    stim_mode = 3;
    wr(0, 32'h1);
    repeat (300) @(negedge clk);
    stim_mode = 1;
    for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
    chk("R4 irq at expiry", irq, 1);
    stim_mode = 2;
    rd(8, v); chk("R4 counter 0 wrapped", v, 0);
    rd(9, v);
    repeat (20) @(negedge clk);
    rd(9, v2); chk("R4 frozen counter", v2, v);

    // R5: release
    wr(0, 32'h5);
    chk("R5 irq cleared", irq, 0);
    rd(9, v2); chk("R5 value kept", v2 - 1, v);

    // R6: counter 1 wraps before counter 0, no interrupt
    repeat (800) @(negedge clk);
    chk("R6 no irq on wrap", irq, 0);
    rd(9, v); chk("R6 counter 1 wrapped below 0x200", longint'(v < 32'h200), 1);

    summary();
  end
endmodule